// File: doc/BRIEF.md
# Out-of-Band Burst Sequencer

This block drives the character path of a serial transmitter while the link is being brought up. On request it emits one of three out-of-band signals: a host reset, a device initialisation, or a wake signal. Each signal is a fixed number of bursts of the alternating D10.2 character, and every burst is followed by a stretch of electrical idle. The block presents one 10-bit character per clock, plus an idle flag that tells the serializer to hold the line at electrical idle instead of driving the character.

A role input states whether the port acts as host or device. The reset signal may only come from a host and the initialisation signal only from a device. Both have the same shape. The wake signal may come from either side and uses shorter gaps. A request that the role forbids raises a one-cycle error pulse and starts nothing. A request made while a signal is running is dropped. When the final gap has elapsed, the block pulses a completion flag for one cycle and is ready at once for a new request.

Top module: `oob_burst_sequencer`

## Requirements
- R1: While reset is held low and in the first cycle after it, tx_idle is 1 and busy, done and err are 0.
- R2: In every cycle that tx_idle is 0, tx_char equals 10'b0101010101 (hex 155) and busy is 1.
- R3: Each burst is exactly BURST_CHARS (default 16) consecutive cycles with tx_idle at 0.
- R4: After every burst, tx_idle is 1 for LONG_GAP (default 48) cycles for the reset and initialisation signals, and for SHORT_GAP (default 16) cycles for the wake signal.
- R5: A signal is BURST_COUNT (default 6) burst-plus-gap periods. In the cycle after the final gap cycle, done is 1 and busy is 0, and done lasts exactly one cycle.
- R6: A request accepted at a clock edge makes busy 1 and tx_idle 0 in the cycle right after that edge.
- R7: req_kind encodes 0 = reset signal (allowed only with role_is_host = 1), 1 = initialisation signal (allowed only with role_is_host = 0), 2 = wake signal (allowed for either role), 3 = never allowed. A disallowed request sampled while not busy sets err to 1 for the following cycle only, and busy and tx_idle stay unchanged.
- R8: While busy is 1, req_valid, req_kind and role_is_host have no effect: the bursts and gaps in progress keep their timing and err stays 0.
- R9: A request made in the cycle where done is 1 is accepted, and its first burst starts in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock; one character per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| role_is_host | input | 1 | 1 = port acts as host, 0 = device |
| req_valid | input | 1 | Request to start a signal, sampled when not busy |
| req_kind | input | 2 | Signal requested: 0 reset, 1 initialisation, 2 wake, 3 invalid |
| tx_char | output | 10 | Character for the serializer; zero while idle |
| tx_idle | output | 1 | 1 = hold the line at electrical idle |
| busy | output | 1 | A signal is in progress |
| done | output | 1 | One-cycle pulse after the final gap |
| err | output | 1 | One-cycle pulse for a request the role forbids |

## Verification
Every result is due a known number of cycles after the request edge. The first burst character and busy appear in the cycle right after it, and err appears in that same cycle for a forbidden request. Burst n begins at cycle n·(BURST_CHARS+gap) after that edge, and done comes exactly BURST_COUNT·(BURST_CHARS+gap) cycles after it. The bench drives inputs on the falling edge and samples on the next falling edge. It computes the expected idle flag for each cycle from the cycle offset modulo the period, and it walks every role and request-code pair. Inside each running signal it injects a conflicting request and flips the role, then confirms that the timing does not move.

// File: rtl/oob_seq_pkg.sv
// Package: shared types and constants for the out-of-band burst sequencer.
// Assumes a 10-bit character path; the burst character is the same for
// either running disparity, so no disparity state is kept.
package oob_seq_pkg;

    typedef enum logic [1:0] {
        SIG_RESET = 2'd0,
        SIG_INIT  = 2'd1,
        SIG_WAKE  = 2'd2,
        SIG_NONE  = 2'd3
    } oob_sig_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_GAP   = 2'd2
    } seq_state_e;

    localparam int unsigned CHAR_W = 10;
    localparam logic [CHAR_W-1:0] BURST_CHAR = 10'b0101010101;

endpackage

// File: rtl/oob_role_gate.sv
// Module: decides whether a requested signal is allowed for the current role.
// Assumes a purely combinational check; the caller samples the result only
// when it is ready to accept a request.
module oob_role_gate
    import oob_seq_pkg::*;
(
    input  logic       role_is_host,
    input  logic [1:0] kind,
    output logic       allowed
);

    // Allowed-signal decode by role.
    always_comb begin
        case (kind)
            SIG_RESET: allowed = role_is_host;
            SIG_INIT:  allowed = !role_is_host;
            SIG_WAKE:  allowed = 1'b1;
            default:   allowed = 1'b0;
        endcase
    end

endmodule

// File: rtl/oob_tick_counter.sv
// Module: wrapping counter with a run-time limit and a terminal flag.
// Assumes limit >= 1 whenever step is high; clear wins over step.
module oob_tick_counter #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         at_last
);

    // Terminal count detect.
    assign at_last = (count == limit - W'(1));

    // Count up, wrap to zero after the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (step) begin
            count <= at_last ? '0 : count + W'(1);
        end
    end

endmodule

// File: rtl/oob_burst_sequencer.sv
// Module: out-of-band burst sequencer (top).
// Emits BURST_COUNT bursts of BURST_CHARS fixed characters, each followed by
// an idle gap whose length depends on the latched signal type, then pulses
// done. Assumes one character per clock and that the role is checked only
// when a request is accepted.
module oob_burst_sequencer
    import oob_seq_pkg::*;
#(
    parameter int unsigned BURST_CHARS = 16,
    parameter int unsigned LONG_GAP    = 48,
    parameter int unsigned SHORT_GAP   = 16,
    parameter int unsigned BURST_COUNT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              role_is_host,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    output logic [CHAR_W-1:0] tx_char,
    output logic              tx_idle,
    output logic              busy,
    output logic              done,
    output logic              err
);

    localparam int unsigned SPAN_MAX = (LONG_GAP > BURST_CHARS) ?
        ((LONG_GAP > SHORT_GAP) ? LONG_GAP : SHORT_GAP) :
        ((BURST_CHARS > SHORT_GAP) ? BURST_CHARS : SHORT_GAP);
    localparam int unsigned CNT_W = $clog2(SPAN_MAX + 1);
    localparam int unsigned BC_W  = $clog2(BURST_COUNT + 1);

    seq_state_e       state;
    oob_sig_e         kind_q;
    logic             allowed;
    logic [CNT_W-1:0] gap_len;
    logic [CNT_W-1:0] char_limit;
    logic [CNT_W-1:0] char_count;
    logic             char_last;
    logic [BC_W-1:0]  burst_idx;
    logic             burst_last;
    logic             burst_step;

    oob_role_gate u_gate (
        .role_is_host (role_is_host),
        .kind         (req_kind),
        .allowed      (allowed)
    );

    // Gap length from the latched signal type.
    assign gap_len = (kind_q == SIG_WAKE) ? CNT_W'(SHORT_GAP) : CNT_W'(LONG_GAP);

    // Character counter limit follows the current phase.
    assign char_limit = (state == ST_GAP) ? gap_len : CNT_W'(BURST_CHARS);

    oob_tick_counter #(.W(CNT_W)) u_char_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state == ST_IDLE),
        .step    (state != ST_IDLE),
        .limit   (char_limit),
        .count   (char_count),
        .at_last (char_last)
    );

    // One burst period ends on the last gap character.
    assign burst_step = (state == ST_GAP) && char_last;

    oob_tick_counter #(.W(BC_W)) u_burst_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state == ST_IDLE),
        .step    (burst_step),
        .limit   (BC_W'(BURST_COUNT)),
        .count   (burst_idx),
        .at_last (burst_last)
    );

    // Phase sequencing, request acceptance and the two pulse outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            kind_q <= SIG_WAKE;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (allowed) begin
                            state  <= ST_BURST;
                            kind_q <= oob_sig_e'(req_kind);
                        end else begin
                            err <= 1'b1;
                        end
                    end
                end
                ST_BURST: begin
                    if (char_last) state <= ST_GAP;
                end
                ST_GAP: begin
                    if (char_last) begin
                        if (burst_last) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state <= ST_BURST;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the phase.
    assign tx_idle = (state != ST_BURST);
    assign tx_char = (state == ST_BURST) ? BURST_CHAR : '0;
    assign busy    = (state != ST_IDLE);

endmodule

// File: rtl/oob_seq_checker.sv
// Module: property checker for the burst sequencer, attached by bind.
// Measures burst and gap runs with its own counters instead of deep $past.
module oob_seq_checker #(
    parameter int unsigned BURST_CHARS = 16,
    parameter int unsigned LONG_GAP    = 48,
    parameter int unsigned SHORT_GAP   = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       role_is_host,
    input logic       req_valid,
    input logic [1:0] req_kind,
    input logic [9:0] tx_char,
    input logic       tx_idle,
    input logic       busy,
    input logic       done,
    input logic       err
);

    logic [15:0] burst_run;
    logic [15:0] gap_run;

    // Length of the current run of driven characters.
    always_ff @(posedge clk) begin
        if (!rst_n)        burst_run <= '0;
        else if (!tx_idle) burst_run <= burst_run + 16'd1;
        else               burst_run <= '0;
    end

    // Length of the current idle run inside a signal.
    always_ff @(posedge clk) begin
        if (!rst_n)                gap_run <= '0;
        else if (busy && tx_idle)  gap_run <= gap_run + 16'd1;
        else                       gap_run <= '0;
    end

    a_r2_char_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_idle |-> (tx_char == 10'b0101010101) && busy);

    a_r3_burst_length: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_idle && burst_run != 16'd0) |-> burst_run == 16'(BURST_CHARS));

    a_r4_gap_length: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_idle && gap_run != 16'd0) |->
            (gap_run == 16'(LONG_GAP) || gap_run == 16'(SHORT_GAP)));

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && tx_idle);

    a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(req_valid) && !$past(busy));

    a_r7_role_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid) &&
            (($past(req_kind) == 2'd2) ||
             ($past(req_kind) == 2'd0 && $past(role_is_host)) ||
             ($past(req_kind) == 2'd1 && !$past(role_is_host))));

    a_r8_no_err_busy: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

endmodule

bind oob_burst_sequencer oob_seq_checker #(
    .BURST_CHARS (BURST_CHARS),
    .LONG_GAP    (LONG_GAP),
    .SHORT_GAP   (SHORT_GAP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .role_is_host (role_is_host),
    .req_valid    (req_valid),
    .req_kind     (req_kind),
    .tx_char      (tx_char),
    .tx_idle      (tx_idle),
    .busy         (busy),
    .done         (done),
    .err          (err)
);

// File: tb/oob_burst_sequencer_test.sv
// Bench: sweeps every role and request code, checks every cycle of each
// signal against arithmetic expectations; inputs change and outputs are
// sampled on the falling edge.
module oob_burst_sequencer_test;

    localparam int BURST = 16;
    localparam int LGAP  = 48;
    localparam int SGAP  = 16;
    localparam int NB    = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       role_is_host = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [9:0] tx_char;
    logic       tx_idle;
    logic       busy;
    logic       done;
    logic       err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    oob_burst_sequencer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .role_is_host (role_is_host),
        .req_valid    (req_valid),
        .req_kind     (req_kind),
        .tx_char      (tx_char),
        .tx_idle      (tx_idle),
        .busy         (busy),
        .done         (done),
        .err          (err)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired: actual=%0d expected<=50000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Request one signal and check it cycle by cycle; optional chained request.
    task automatic run_case(input bit role, input logic [1:0] kind, input bit chain);
        bit allowed;
        int gap;
        int per;
        int total;
        allowed = (kind == 2'd2) || (kind == 2'd0 && role) || (kind == 2'd1 && !role);
        @(negedge clk);
        role_is_host = role;
        req_kind     = kind;
        req_valid    = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (!allowed) begin
            chk(err == 1'b1, "R7 err pulse", err, 1);
            chk(busy == 1'b0, "R7 no start busy", busy, 0);
            chk(tx_idle == 1'b1, "R7 no start idle", tx_idle, 1);
            @(negedge clk);
            chk(err == 1'b0, "R7 err one cycle", err, 0);
            chk(busy == 1'b0, "R7 still idle", busy, 0);
            return;
        end
        chk(err == 1'b0, "R7 allowed no err", err, 0);
        gap   = (kind == 2'd2) ? SGAP : LGAP;
        per   = BURST + gap;
        total = NB * per;
        for (int c = 0; c < total; c++) begin
            bit exp_idle;
            if (c > 0) @(negedge clk);
            req_valid = 1'b0;
            exp_idle = (c % per) >= BURST;
            if (c == 0) chk(tx_idle == 1'b0 && busy == 1'b1, "R6 first char", {busy, tx_idle}, 2);
            chk(tx_idle == exp_idle, "R3 R4 idle pattern", tx_idle, exp_idle);
            if (!exp_idle) chk(tx_char == 10'h155, "R2 burst char", tx_char, 10'h155);
            chk(busy == 1'b1, "R5 busy during signal", busy, 1);
            chk(done == 1'b0, "R5 no early done", done, 0);
            chk(err == 1'b0, "R8 no err while busy", err, 0);
            if (c == 20 || c == 100) begin
                req_valid = 1'b1;
                req_kind  = (kind == 2'd2) ? 2'd0 : 2'd2;
            end
            if (c == 30) role_is_host = !role;
            if (c == 50) begin
                req_valid = 1'b1;
                req_kind  = 2'd3;
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(done == 1'b1, "R5 done pulse", done, 1);
        chk(busy == 1'b0, "R5 busy falls", busy, 0);
        chk(tx_idle == 1'b1, "R5 idle after", tx_idle, 1);
        if (chain) begin
            role_is_host = 1'b0;
            req_kind     = 2'd2;
            req_valid    = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            chk(busy == 1'b1 && tx_idle == 1'b0, "R9 chained start", {busy, tx_idle}, 2);
            chk(done == 1'b0, "R5 done one cycle", done, 0);
            for (int w = 0; w < 2000 && !done; w++) @(negedge clk);
            chk(done == 1'b1, "R9 chained done", done, 1);
            @(negedge clk);
        end else begin
            @(negedge clk);
            chk(done == 1'b0, "R5 done one cycle", done, 0);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(tx_idle == 1'b1, "R1 reset idle", tx_idle, 1);
        chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R1 reset flags",
            {busy, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_idle == 1'b1 && busy == 1'b0, "R1 after reset", {busy, tx_idle}, 1);
        for (int r = 0; r < 2; r++) begin
            for (int k = 0; k < 4; k++) begin
                run_case(r[0], k[1:0], 1'b0);
            end
        end
        run_case(1'b1, 2'd0, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule